// File: doc/BRIEF.md
# GPIO interrupt routing mux

This block routes a large set of GPIO pad inputs onto a small number of interrupt channels. It conditions each channel for a downstream interrupt controller that accepts only active-high level requests or rising-edge requests. Every channel picks any one pad through an 8-bit index. The picked pad goes through a synchroniser. The channel can then optionally invert it, pass it through a glitch filter whose strength is set by software, and present it downstream either as a level or as a one-cycle pulse.

Inversion is what lets active-low and falling-edge sources reach a controller that cannot sense them natively. A channel senses one edge direction at a time; the invert bit picks which one. Software programs the channels through a plain 32-bit word-wide register port with combinational read data. Changing a channel's pad or polarity in edge mode does not produce a false pulse.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, all four configuration words read zero and every interrupt output is low. This gives level mode, no inversion, pad 0 and no filtering on every channel.
- R2: Each configuration word reads back what was last written to its implemented fields. In the word at offset 0x00, bits 15:8 and 31:24 always read zero.
- R3: Channel n (0 to 3) takes its pad index from byte (n mod 4) of the word at offset 0x04, at bits [8(n mod 4)+7 : 8(n mod 4)]. Channels 4 to 7 take theirs from the same byte positions of offset 0x08. A channel responds only to the pad it selects.
- R4: In level mode (bit n of offset 0x00 clear) with filter setting 0, `irq_out[n]` equals the selected pad XOR the channel's invert bit. A pad change becomes visible after the second rising clock edge that follows it.
- R5: Bit 16+n of offset 0x00 inverts channel n. In level mode this gives active-low sensing; in edge mode it gives falling-edge sensing. The inversion takes effect from the clock edge that writes it.
- R6: Bit n of offset 0x00 puts channel n in edge mode. `irq_out[n]` then pulses high for exactly one cycle on each 0-to-1 transition of the polarity-corrected, filtered signal, and stays low on 1-to-0 transitions.
- R7: Bits [4n+3:4n] of offset 0x0C hold filter setting F for channel n. With F greater than 0, the filtered value changes only after the corrected input has differed from it for 8F consecutive cycles, so a pad change is seen after 2+8F edges. Shorter glitches are dropped entirely.
- R8: Rewriting a channel's pad index or invert bit in edge mode never causes a pulse. The synchroniser, filter and edge history settle on the new source before pulses are enabled again.
- R9: Writes to byte offsets other than 0x00, 0x04, 0x08 and 0x0C change no configuration, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Write strobe for the configuration port |
| reg_addr | input | ADDR_W (4) | Byte offset of the configuration word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | N_PADS (256) | Asynchronous GPIO pad levels |
| irq_out | output | N_CH (8) | Active-high requests to the interrupt controller |

## Verification
The bench sweeps every pad index on every channel and checks that only channels selecting that pad move, and only after exactly two edges. A byte misplaced in a select word, or a missing synchroniser stage, fails this sweep at once. Filter settings 1, 2 and 15 are each driven with a step that arrives one cycle early and one cycle on time, and with a glitch one cycle shorter than the window; an off-by-one counter either passes the glitch or answers late. In edge mode the bench flips the invert bit and moves the pad index onto a pad that is already high. A design that does not reload the edge history on reconfiguration pulses there.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int unsigned REG_W        = 32;
   localparam int unsigned OFS_MODE     = 32'h0;
   localparam int unsigned OFS_SEL_LO   = 32'h4;
   localparam int unsigned OFS_SEL_HI   = 32'h8;
   localparam int unsigned OFS_FILT     = 32'hC;
   localparam int unsigned INV_BASE     = 16;
   localparam int unsigned SEL_SLOT     = 8;
   localparam int unsigned SEL_PER_WORD = 4;
   localparam int unsigned FILT_SLOT    = 4;

   typedef enum logic [2:0] {
      AD_MODE,
      AD_SEL_LO,
      AD_SEL_HI,
      AD_FILT,
      AD_NONE
   } reg_dec_e;

   function automatic reg_dec_e decode_addr(input logic [31:0] a);
      case (a)
         OFS_MODE:   return AD_MODE;
         OFS_SEL_LO: return AD_SEL_LO;
         OFS_SEL_HI: return AD_SEL_HI;
         OFS_FILT:   return AD_FILT;
         default:    return AD_NONE;
      endcase
   endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned N_CH   = 8,
   parameter int unsigned SEL_W  = 8,
   parameter int unsigned FILT_W = 4,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wen,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [REG_W-1:0]                wdata,
   output logic [REG_W-1:0]                rdata,
   output logic [N_CH-1:0]                 edge_mode,
   output logic [N_CH-1:0]                 invert,
   output logic [N_CH-1:0][SEL_W-1:0]      sel,
   output logic [N_CH-1:0][FILT_W-1:0]     filt
);

   localparam int unsigned PAD_A = REG_W - ADDR_W;

   reg_dec_e dec;
   assign dec = decode_addr({{PAD_A{1'b0}}, addr});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_mode <= '0;
         invert    <= '0;
         sel       <= '0;
         filt      <= '0;
      end else if (wen) begin
         for (int unsigned n = 0; n < N_CH; n++) begin
            if (dec == AD_MODE) begin
               edge_mode[n] <= wdata[n];
               invert[n]    <= wdata[INV_BASE + n];
            end
            if ((dec == AD_SEL_LO && n < SEL_PER_WORD) ||
                (dec == AD_SEL_HI && n >= SEL_PER_WORD))
               sel[n] <= wdata[(n % SEL_PER_WORD) * SEL_SLOT +: SEL_W];
            if (dec == AD_FILT)
               filt[n] <= wdata[n * FILT_SLOT +: FILT_W];
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int unsigned n = 0; n < N_CH; n++) begin
         case (dec)
            AD_MODE: begin
               rdata[n]            = edge_mode[n];
               rdata[INV_BASE + n] = invert[n];
            end
            AD_SEL_LO: if (n < SEL_PER_WORD)
               rdata[(n % SEL_PER_WORD) * SEL_SLOT +: SEL_W] = sel[n];
            AD_SEL_HI: if (n >= SEL_PER_WORD)
               rdata[(n % SEL_PER_WORD) * SEL_SLOT +: SEL_W] = sel[n];
            AD_FILT:
               rdata[n * FILT_SLOT +: FILT_W] = filt[n];
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad
      $error("gpio_irq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
   parameter int unsigned FILT_W    = 4,
   parameter int unsigned UNIT_LOG2 = 3,
   parameter bit          FILTER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din,
   input  logic [FILT_W-1:0] setting,
   input  logic              reload,
   output logic              dout
);

   localparam int unsigned CNT_W = FILT_W + UNIT_LOG2;

   if (FILTER_EN) begin : g_filter
      logic             state;
      logic [CNT_W-1:0] cnt;
      logic [CNT_W-1:0] limit;
      logic             bypass;

      assign bypass = (setting == '0);
      assign limit  = {setting, {UNIT_LOG2{1'b0}}} - CNT_W'(1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            state <= 1'b0;
            cnt   <= '0;
         end else if (reload || bypass) begin
            state <= din;
            cnt   <= '0;
         end else if (din == state) begin
            cnt <= '0;
         end else if (cnt == limit) begin
            state <= din;
            cnt   <= '0;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end

      assign dout = bypass ? din : state;
   end else begin : g_bypass
      logic unused_filt;
      assign unused_filt = ^{clk, rst_n, setting, reload};
      assign dout = din;
   end

endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan #(
   parameter int unsigned N_PADS      = 256,
   parameter int unsigned SEL_W       = 8,
   parameter int unsigned FILT_W      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned UNIT_LOG2   = 3,
   parameter bit          FILTER_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PADS-1:0] pads,
   input  logic [SEL_W-1:0]  sel,
   input  logic              invert,
   input  logic              edge_mode,
   input  logic [FILT_W-1:0] filt,
   output logic              irq,
   output logic              quiet
);

   localparam int unsigned SETTLE = SYNC_STAGES + 1;
   localparam int unsigned SET_W  = $clog2(SETTLE + 1);

   logic             picked;
   logic             synced;
   logic             cond;
   logic             filtered;
   logic             hist;
   logic [SEL_W-1:0] sel_q;
   logic             inv_q;
   logic             chg;
   logic [SET_W-1:0] settle_q;

   assign picked = pads[sel];

   gpio_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (picked),
      .q     (synced)
   );

   assign cond = synced ^ invert;

   // Source or polarity moved: hold pulses off until the new source has
   // crossed the synchroniser and the filter and history are reloaded.
   assign chg   = (sel != sel_q) || (invert != inv_q);
   assign quiet = chg || (settle_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= '0;
         inv_q    <= 1'b0;
         settle_q <= '0;
      end else begin
         sel_q <= sel;
         inv_q <= invert;
         if (chg)                 settle_q <= SET_W'(SETTLE);
         else if (settle_q != '0) settle_q <= settle_q - SET_W'(1);
      end
   end

   gpio_irq_filter #(
      .FILT_W    (FILT_W),
      .UNIT_LOG2 (UNIT_LOG2),
      .FILTER_EN (FILTER_EN)
   ) u_filter (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (cond),
      .setting (filt),
      .reload  (quiet),
      .dout    (filtered)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist <= 1'b0;
      else        hist <= filtered;
   end

   assign irq = edge_mode ? (filtered & ~hist & ~quiet) : filtered;

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
   import gpio_irq_pkg::*;
#(
   parameter int unsigned N_PADS      = 256,
   parameter int unsigned N_CH        = 8,
   parameter int unsigned FILT_W      = 4,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned UNIT_LOG2   = 3,
   parameter bit          FILTER_EN   = 1'b1,
   localparam int unsigned SEL_W      = $clog2(N_PADS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wen,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [N_PADS-1:0] pad_in,
   output logic [N_CH-1:0]   irq_out
);

   if (N_CH < 1 || N_CH > 2 * SEL_PER_WORD) begin : g_bad_ch
      $error("gpio_irq_router: N_CH must be 1..8");
   end
   if (SEL_W < 1 || SEL_W > SEL_SLOT) begin : g_bad_sel
      $error("gpio_irq_router: N_PADS must be 2..256");
   end
   if (FILT_W < 1 || FILT_W > FILT_SLOT) begin : g_bad_filt
      $error("gpio_irq_router: FILT_W must be 1..4");
   end
   if (ADDR_W < 4 || ADDR_W > 16) begin : g_bad_addr
      $error("gpio_irq_router: ADDR_W must be 4..16");
   end

   logic [N_CH-1:0]              mode_v;
   logic [N_CH-1:0]              inv_v;
   logic [N_CH-1:0][SEL_W-1:0]   sel_v;
   logic [N_CH-1:0][FILT_W-1:0]  filt_v;
   logic [N_CH-1:0]              chan_quiet;

   gpio_irq_regs #(
      .N_CH   (N_CH),
      .SEL_W  (SEL_W),
      .FILT_W (FILT_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wen       (reg_wen),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .edge_mode (mode_v),
      .invert    (inv_v),
      .sel       (sel_v),
      .filt      (filt_v)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      gpio_irq_chan #(
         .N_PADS      (N_PADS),
         .SEL_W       (SEL_W),
         .FILT_W      (FILT_W),
         .SYNC_STAGES (SYNC_STAGES),
         .UNIT_LOG2   (UNIT_LOG2),
         .FILTER_EN   (FILTER_EN)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .pads      (pad_in),
         .sel       (sel_v[c]),
         .invert    (inv_v[c]),
         .edge_mode (mode_v[c]),
         .filt      (filt_v[c]),
         .irq       (irq_out[c]),
         .quiet     (chan_quiet[c])
      );
   end

endmodule

// File: rtl/gpio_irq_router_checker.sv
module gpio_irq_router_checker
   import gpio_irq_pkg::*;
#(
   parameter int unsigned N_CH   = 8,
   parameter int unsigned SEL_W  = 8,
   parameter int unsigned FILT_W = 4,
   parameter int unsigned ADDR_W = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     reg_wen,
   input logic [ADDR_W-1:0]        reg_addr,
   input logic [31:0]              reg_rdata,
   input logic [N_CH-1:0]          irq_out,
   input logic [N_CH-1:0]          chan_quiet,
   input logic [N_CH-1:0]          mode_v,
   input logic [N_CH-1:0]          inv_v,
   input logic [N_CH*SEL_W-1:0]    sel_v,
   input logic [N_CH*FILT_W-1:0]   filt_v
);

   localparam int unsigned GAP = 16 - N_CH;
   localparam logic [31:0] MODE_USED =
      {{GAP{1'b0}}, {N_CH{1'b1}}, {GAP{1'b0}}, {N_CH{1'b1}}};

   reg_dec_e dec;
   assign dec = decode_addr({{(32 - ADDR_W){1'b0}}, reg_addr});

   // R6: an edge-mode request never lasts two cycles
   assert_edge_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_out & mode_v & $past(irq_out & mode_v)) == '0));

   // R8: no edge request while a channel is settling after reconfiguration
   assert_quiet_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((chan_quiet & mode_v & irq_out) == '0));

   // R2: unimplemented bits of the mode word read zero
   assert_mode_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dec == AD_MODE) |-> ((reg_rdata & ~MODE_USED) == '0));

   // R9: writes to undecoded offsets leave every field untouched
   assert_bad_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wen && dec == AD_NONE) |=>
         ($stable(mode_v) && $stable(inv_v) && $stable(sel_v) && $stable(filt_v)));

   // R9: undecoded offsets read zero
   assert_bad_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dec == AD_NONE) |-> (reg_rdata == '0));

endmodule

bind gpio_irq_router gpio_irq_router_checker #(
   .N_CH   (N_CH),
   .SEL_W  (SEL_W),
   .FILT_W (FILT_W),
   .ADDR_W (ADDR_W)
) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wen    (reg_wen),
   .reg_addr   (reg_addr),
   .reg_rdata  (reg_rdata),
   .irq_out    (irq_out),
   .chan_quiet (chan_quiet),
   .mode_v     (mode_v),
   .inv_v      (inv_v),
   .sel_v      (sel_v),
   .filt_v     (filt_v)
);

// File: tb/gpio_irq_router_bench.sv
`timescale 1ns/1ps
module gpio_irq_router_bench;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wen = 1'b0;
   logic [3:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic [255:0] pads = '0;
   logic [7:0]   irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] b_sel [8];
   logic [3:0] b_filt [8];
   logic [7:0] b_mode = '0;
   logic [7:0] b_inv  = '0;

   always #2 clk = ~clk;

   gpio_irq_router u_gpio_irq_router (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wen   (reg_wen),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pad_in    (pads),
      .irq_out   (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
      step(1);
      reg_wen = 1'b0;
   endtask

   task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
      step(1);
   endtask

   task automatic push_mode();
      wr(4'h0, {8'h0, b_inv, 8'h0, b_mode});
   endtask

   task automatic push_sel(input int c);
      int base;
      base = (c / 4) * 4;
      wr((c < 4) ? 4'h4 : 4'h8,
         {b_sel[base+3], b_sel[base+2], b_sel[base+1], b_sel[base]});
   endtask

   task automatic push_filt();
      wr(4'hC, {b_filt[7], b_filt[6], b_filt[5], b_filt[4],
                b_filt[3], b_filt[2], b_filt[1], b_filt[0]});
   endtask

   function automatic logic [7:0] level_exp();
      logic [7:0] r;
      for (int c = 0; c < 8; c++) r[c] = pads[b_sel[c]] ^ b_inv[c];
      return r;
   endfunction

   initial begin
      for (int c = 0; c < 8; c++) begin b_sel[c] = '0; b_filt[c] = '0; end
      step(4);
      rst_n = 1'b1;
      step(1);

      // R1: reset state
      rd("R1", 4'h0, 32'h0);
      rd("R1", 4'h4, 32'h0);
      rd("R1", 4'h8, 32'h0);
      rd("R1", 4'hC, 32'h0);
      chk("R1", {24'h0, irq}, 32'h0);

      // R2: readback, unused mode bits zero
      wr(4'h0, 32'hFFFF_FFFF);
      rd("R2", 4'h0, 32'h00FF_00FF);
      wr(4'h4, 32'hA5C3_7E19);
      rd("R2", 4'h4, 32'hA5C3_7E19);
      wr(4'h8, 32'h1234_5678);
      rd("R2", 4'h8, 32'h1234_5678);
      wr(4'hC, 32'h8765_4321);
      rd("R2", 4'hC, 32'h8765_4321);
      wr(4'h0, 32'h0); wr(4'h4, 32'h0); wr(4'h8, 32'h0); wr(4'hC, 32'h0);
      step(5);

      // R9: undecoded offsets
      wr(4'h2, 32'hFFFF_FFFF);
      wr(4'h5, 32'hFFFF_FFFF);
      wr(4'hE, 32'hFFFF_FFFF);
      rd("R9", 4'h2, 32'h0);
      rd("R9", 4'h0, 32'h0);
      rd("R9", 4'h4, 32'h0);
      rd("R9", 4'hC, 32'h0);
      chk("R9", {24'h0, irq}, 32'h0);

      // R3 / R4: every pad on every channel, level mode, no filter
      for (int c = 0; c < 8; c++) begin
         for (int p = 0; p < 256; p++) begin
            b_sel[c] = 8'(p);
            push_sel(c);
            step(4);
            pads[p] = 1'b1;
            step(1);
            chk("R4", {31'h0, irq[c]}, 32'h0);
            step(1);
            chk("R3", {24'h0, irq}, {24'h0, level_exp()});
            pads[p] = 1'b0;
            step(2);
            chk("R3", {24'h0, irq}, {24'h0, level_exp()});
         end
      end

      // R5: level inversion takes effect with the write
      for (int c = 0; c < 8; c++) b_sel[c] = 8'(20 + c);
      for (int c = 0; c < 8; c += 4) push_sel(c);
      step(4);
      b_inv = 8'hFF;
      push_mode();
      chk("R5", {24'h0, irq}, 32'hFF);
      pads[23] = 1'b1;
      step(2);
      chk("R5", {24'h0, irq}, 32'hF7);
      pads[23] = 1'b0;
      b_inv = 8'h00;
      push_mode();
      step(4);

      // R6: edge mode single pulse on rising edge only
      b_mode = 8'hFF;
      push_mode();
      step(5);
      chk("R8", {24'h0, irq}, 32'h0);
      pads[22] = 1'b1;
      step(1);
      chk("R6", {24'h0, irq}, 32'h0);
      step(1);
      chk("R6", {24'h0, irq}, 32'h04);
      step(1);
      chk("R6", {24'h0, irq}, 32'h0);
      step(3);
      chk("R6", {24'h0, irq}, 32'h0);
      pads[22] = 1'b0;
      begin
         logic [7:0] seen = '0;
         for (int i = 0; i < 5; i++) begin step(1); seen |= irq; end
         chk("R6", {24'h0, seen}, 32'h0);
      end

      // R8 + R5: flip invert in edge mode, then falling-edge sensing
      b_inv[2] = 1'b1;
      begin
         logic [7:0] seen = '0;
         push_mode();
         seen |= irq;
         for (int i = 0; i < 6; i++) begin step(1); seen |= irq; end
         chk("R8", {24'h0, seen}, 32'h0);
      end
      pads[22] = 1'b1;
      step(3);
      chk("R5", {24'h0, irq}, 32'h0);
      pads[22] = 1'b0;
      step(2);
      chk("R5", {24'h0, irq}, 32'h04);
      step(1);
      chk("R5", {24'h0, irq}, 32'h0);

      // R8: move a channel onto a pad that is already high
      pads[200] = 1'b1;
      step(3);
      b_sel[4] = 8'd200;
      begin
         logic [7:0] seen = '0;
         push_sel(4);
         seen |= irq;
         for (int i = 0; i < 8; i++) begin step(1); seen |= irq; end
         chk("R8", {24'h0, seen}, 32'h0);
      end
      pads[200] = 1'b0;
      b_mode = 8'h00; b_inv = 8'h00;
      push_mode();
      step(5);

      // R7: filter windows of 8F cycles
      b_sel[1] = 8'd50;
      push_sel(1);
      step(5);
      foreach (b_filt[k]) b_filt[k] = '0;
      for (int fi = 0; fi < 3; fi++) begin
         int f;
         f = (fi == 0) ? 1 : (fi == 1) ? 2 : 15;
         b_filt[1] = 4'(f);
         push_filt();
         step(2);
         pads[50] = 1'b1;
         step(1 + 8 * f);
         chk("R7", {31'h0, irq[1]}, 32'h0);
         step(1);
         chk("R7", {31'h0, irq[1]}, 32'h1);
         pads[50] = 1'b0;
         step(1 + 8 * f);
         chk("R7", {31'h0, irq[1]}, 32'h1);
         step(1);
         chk("R7", {31'h0, irq[1]}, 32'h0);
         begin
            logic seen = 1'b0;
            pads[50] = 1'b1;
            step(8 * f - 1);
            pads[50] = 1'b0;
            for (int i = 0; i < 8 * f + 4; i++) begin step(1); seen |= irq[1]; end
            chk("R7", {31'h0, seen}, 32'h0);
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule